// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block gathers a wide vector of level-sensitive interrupt lines into groups of eight and drives one combined request per group toward a parent interrupt controller. A group request is high whenever at least one of its enabled lines is high, and drops as soon as no enabled line in the group remains high. Each group request is a combinational function of the inputs and the enable state.

Software controls masking through a small synchronous register port made of an address, a write strobe with write data, and a combinational read-data output. Four groups share one 32-bit register bank, and banks repeat every 16 bytes. Within a bank, the enable bits change only through two write-one registers: one sets bits and one clears them. A third register shows the masked pending lines. Input line `g*8 + k` is bit `k` of group `g`. Group `g` lives in bank `g/4`, at bits `(g%4)*8` to `(g%4)*8+7`.

Top module: `irq_group_combiner`

## Requirements
- R1: After reset every enable bit is 0, so all group outputs are low and every readable register reads 0, even with all inputs high.
- R2: A write to bank offset 0x0 enables each line whose data bit is 1 and leaves lines written with 0 unchanged.
- R3: A write to bank offset 0x4 disables each line whose data bit is 1 and leaves lines written with 0 unchanged.
- R4: A read of bank offset 0xC returns the bank's input lines ANDed with their enable bits, with group `g` at bits `(g%4)*8` and up.
- R5: Group output `g` equals the OR of the eight masked lines of group `g` in the same cycle and follows the input level with no latching.
- R6: Offset 0x8 and any offset not listed here read as 0, and a write to them changes no enable bit.
- R7: Addresses whose bank index (address divided by 16) is at or past the number of banks read as 0, and a write to them changes no enable bit. No such address aliases onto a real bank.
- R8: Reads of offset 0x0 or 0x4 return the bank's current enable bits.
- R9: Writes to the status offset 0xC change no enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | N_GROUPS*8 (160) | Level interrupt lines, line g*8+k is group g bit k |
| reg_addr | input | ADDR_W (8) | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| grp_irq | output | N_GROUPS (20) | Combined request per group |

## Verification
The bench runs a behavioural model of the enable state and compares every group output and the read data on every cycle. It issues set and clear writes with mixed ones and zeros, so a design that overwrote the enable register instead of setting or clearing bits would lose enables it should keep. The bench also writes to offset 0x8, to the status offset and to out-of-range banks. A decoder that ignored the offset, or wrapped the bank index, would then corrupt real enable bits or return non-zero reads. Inputs change without any writes while enables are set, which catches a group output that latched its value or used the wrong bit lanes of a bank.

// File: rtl/grpcomb_pkg.sv
package grpcomb_pkg;

   localparam logic [3:0] OFF_SET  = 4'h0;
   localparam logic [3:0] OFF_CLR  = 4'h4;
   localparam logic [3:0] OFF_STAT = 4'hC;

   // number of groups that land in bank b
   function automatic int groups_in_bank(input int b, input int n_groups, input int per_bank);
      int rem;
      rem = n_groups - b * per_bank;
      if (rem > per_bank) return per_bank;
      if (rem < 0) return 0;
      return rem;
   endfunction

   function automatic int ceil_div(input int a, input int b);
      return (a + b - 1) / b;
   endfunction

endpackage

// File: rtl/grpcomb_decode.sv
module grpcomb_decode
   import grpcomb_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int N_BANKS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output logic [N_BANKS-1:0] bank_sel,
   output logic              hit_set,
   output logic              hit_clr,
   output logic              hit_stat,
   output logic              wr_set,
   output logic              wr_clr
);
   localparam int IDX_W = ADDR_W - 4;

   logic [IDX_W-1:0] idx;
   logic [3:0]       off;

   assign idx = addr[ADDR_W-1:4];
   assign off = addr[3:0];

   generate
      if (IDX_W < 1) begin : g_bad_addr
         $error("ADDR_W too small for 16-byte banks");
      end
      if (N_BANKS > (1 << IDX_W)) begin : g_bad_span
         $error("ADDR_W cannot reach all banks");
      end
      for (genvar b = 0; b < N_BANKS; b++) begin : g_sel
         assign bank_sel[b] = (idx == IDX_W'(b));
      end
   endgenerate

   assign hit_set  = (off == OFF_SET);
   assign hit_clr  = (off == OFF_CLR);
   assign hit_stat = (off == OFF_STAT);
   assign wr_set   = wr & hit_set;
   assign wr_clr   = wr & hit_clr;

   // R7: at most one bank answers any address
   p_sel_r7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(bank_sel));

endmodule

// File: rtl/grpcomb_bank.sv
module grpcomb_bank #(
   parameter int GROUP_W = 8,
   parameter int SLOTS   = 4,
   parameter int GROUPS  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [GROUPS*GROUP_W-1:0] irq,
   input  logic                      set_we,
   input  logic                      clr_we,
   input  logic [SLOTS*GROUP_W-1:0]  wdata,
   output logic [SLOTS*GROUP_W-1:0]  en_q,
   output logic [SLOTS*GROUP_W-1:0]  stat,
   output logic [GROUPS-1:0]         grp
);
   localparam int DATA_W = SLOTS * GROUP_W;
   localparam int USED   = GROUPS * GROUP_W;

   logic [USED-1:0] en_r;
   logic [USED-1:0] stat_u;

   generate
      if (GROUPS < 1 || GROUPS > SLOTS) begin : g_bad_groups
         $error("bank group count out of range");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         en_r <= '0;
      else if (clr_we)
         en_r <= en_r & ~wdata[USED-1:0];
      else if (set_we)
         en_r <= en_r | wdata[USED-1:0];
   end

   assign stat_u = irq & en_r;

   generate
      if (USED < DATA_W) begin : g_pad
         assign en_q = {{(DATA_W-USED){1'b0}}, en_r};
         assign stat = {{(DATA_W-USED){1'b0}}, stat_u};
      end else begin : g_full
         assign en_q = en_r;
         assign stat = stat_u;
      end
      for (genvar g = 0; g < GROUPS; g++) begin : g_or
         assign grp[g] = |stat_u[g*GROUP_W +: GROUP_W];
      end
   endgenerate

   // R2: every bit written as 1 to set is enabled afterwards
   p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && !clr_we) |=> ((en_r & $past(wdata[USED-1:0])) == $past(wdata[USED-1:0])));
   // R3: every bit written as 1 to clear is disabled afterwards
   p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((en_r & $past(wdata[USED-1:0])) == '0));
   // R6/R7/R9: enables hold when this bank gets no set or clear write
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(en_r));
   // R5: a group request needs some input line high
   p_grp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|grp) |-> (|irq));

endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
   import grpcomb_pkg::*;
#(
   parameter int N_GROUPS = 20,
   parameter int GROUP_W  = 8,
   parameter int SLOTS    = 4,
   parameter int ADDR_W   = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_GROUPS*GROUP_W-1:0] irq_in,
   input  logic [ADDR_W-1:0]           reg_addr,
   input  logic                        reg_wr,
   input  logic [SLOTS*GROUP_W-1:0]    reg_wdata,
   output logic [SLOTS*GROUP_W-1:0]    reg_rdata,
   output logic [N_GROUPS-1:0]         grp_irq
);
   localparam int DATA_W  = SLOTS * GROUP_W;
   localparam int N_BANKS = ceil_div(N_GROUPS, SLOTS);

   generate
      if (N_GROUPS < 1) begin : g_bad_n
         $error("N_GROUPS must be positive");
      end
   endgenerate

   logic [N_BANKS-1:0] bank_sel;
   logic hit_set, hit_clr, hit_stat, wr_set, wr_clr;
   logic [DATA_W-1:0] en_a   [N_BANKS];
   logic [DATA_W-1:0] stat_a [N_BANKS];

   grpcomb_decode #(.ADDR_W(ADDR_W), .N_BANKS(N_BANKS)) u_dec (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
      .bank_sel(bank_sel), .hit_set(hit_set), .hit_clr(hit_clr),
      .hit_stat(hit_stat), .wr_set(wr_set), .wr_clr(wr_clr)
   );

   generate
      for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
         localparam int CNT = groups_in_bank(b, N_GROUPS, SLOTS);
         localparam int LO  = b * SLOTS;
         grpcomb_bank #(.GROUP_W(GROUP_W), .SLOTS(SLOTS), .GROUPS(CNT)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .irq(irq_in[LO*GROUP_W +: CNT*GROUP_W]),
            .set_we(wr_set & bank_sel[b]),
            .clr_we(wr_clr & bank_sel[b]),
            .wdata(reg_wdata),
            .en_q(en_a[b]),
            .stat(stat_a[b]),
            .grp(grp_irq[LO +: CNT])
         );
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      for (int b = 0; b < N_BANKS; b++) begin
         if (bank_sel[b]) begin
            if (hit_set || hit_clr) reg_rdata = en_a[b];
            else if (hit_stat)      reg_rdata = stat_a[b];
         end
      end
   end

   // R6: the unused offset 0x8 always reads zero
   p_unused_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr[3:0] == 4'h8) |-> (reg_rdata == '0));

endmodule

// File: tb/tb_irq_group_combiner.sv
module tb_irq_group_combiner;
   localparam int CLK_P = 10;
   localparam int NG = 20;
   localparam int NIN = NG * 8;
   localparam int NB = 5;

   logic clk = 0;
   logic rst_n = 0;
   logic [NIN-1:0] irq_in = '0;
   logic [7:0] reg_addr = '0;
   logic reg_wr = 0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [NG-1:0] grp_irq;

   int total = 0;
   int bad = 0;
   bit live = 0;
   logic [NIN-1:0] en_m = '0;

   irq_group_combiner dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .grp_irq(grp_irq)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   // reference enable model
   always @(posedge clk) begin
      if (!rst_n) en_m <= '0;
      else if (reg_wr && (reg_addr >> 4) < NB) begin
         for (int i = 0; i < 32; i++) begin
            int gi;
            gi = (reg_addr >> 4) * 32 + i;
            if (reg_wdata[i] && gi < NIN) begin
               if (reg_addr[3:0] == 4'h0) en_m[gi] <= 1'b1;
               else if (reg_addr[3:0] == 4'h4) en_m[gi] <= 1'b0;
            end
         end
      end
   end

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      logic [31:0] r;
      int bk;
      r = '0;
      bk = a >> 4;
      if (bk < NB) begin
         for (int i = 0; i < 32; i++) begin
            if (a[3:0] == 4'h0 || a[3:0] == 4'h4) r[i] = en_m[bk*32+i];
            else if (a[3:0] == 4'hC) r[i] = en_m[bk*32+i] & irq_in[bk*32+i];
         end
      end
      return r;
   endfunction

   always @(negedge clk) begin
      if (live) begin
         logic [NG-1:0] eg;
         logic [31:0] er;
         string tag;
         for (int g = 0; g < NG; g++) eg[g] = |(irq_in[g*8 +: 8] & en_m[g*8 +: 8]);
         chk(grp_irq == eg, "R5 group output", 32'(grp_irq), 32'(eg));
         er = exp_read(reg_addr);
         if ((reg_addr >> 4) >= NB) tag = "R7 out-of-range read";
         else if (reg_addr[3:0] == 4'hC) tag = "R4 status read";
         else if (reg_addr[3:0] == 4'h0 || reg_addr[3:0] == 4'h4) tag = "R8 enable read / R2 R3 state";
         else tag = "R6 unused offset read";
         chk(reg_rdata == er, tag, reg_rdata, er);
      end
   end

   task automatic step(input logic [7:0] a, input bit w, input logic [31:0] d);
      @(posedge clk); #1;
      reg_addr = a; reg_wr = w; reg_wdata = d;
   endtask

   initial begin
      #(CLK_P * 150000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      irq_in = '1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1: reset state with every line high
      @(negedge clk);
      chk(grp_irq == '0, "R1 outputs after reset", 32'(grp_irq), 0);
      for (int b = 0; b < NB; b++) begin
         reg_addr = 8'(b*16 + 12); #1;
         chk(reg_rdata == 0, "R1 status after reset", reg_rdata, 0);
         reg_addr = 8'(b*16); #1;
         chk(reg_rdata == 0, "R1 enable after reset", reg_rdata, 0);
      end
      live = 1;
      // R2: set with mixed bits, then more bits (earlier ones kept)
      step(8'h00, 1, 32'h0000_00A5);
      step(8'h00, 1, 32'h8001_0100);
      step(8'h00, 0, 0);
      step(8'h0C, 0, 0);
      // R3: clear a subset
      step(8'h04, 1, 32'h0000_0081);
      step(8'h00, 0, 0);
      // R6/R9: writes to 0x8 and status must not alter enables
      step(8'h08, 1, 32'hFFFF_FFFF);
      step(8'h0C, 1, 32'hFFFF_FFFF);
      step(8'h00, 0, 0);
      // R7: out-of-range bank writes must not alias
      step(8'h50, 1, 32'hFFFF_FFFF);
      step(8'hF0, 1, 32'hFFFF_FFFF);
      step(8'h00, 0, 0);
      step(8'h40, 1, 32'h00FF_0000);
      step(8'h4C, 0, 0);
      // R5: level following with no writes
      for (int k = 0; k < 40; k++) begin
         step(8'h0C, 0, 0);
         irq_in = {$urandom, $urandom, $urandom, $urandom, $urandom};
      end
      // random traffic
      for (int k = 0; k < 3000; k++) begin
         step(8'($urandom_range(0, 95)), 1'($urandom_range(0, 1)), $urandom);
         if ($urandom_range(0, 3) == 0) irq_in = {$urandom, $urandom, $urandom, $urandom, $urandom};
         if ($urandom_range(0, 7) == 0) reg_addr = {reg_addr[7:4], 4'hC};
      end
      step(8'h00, 0, 0);
      @(negedge clk); #1;
      live = 0;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule